// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Level Flags

This block is a first-in first-out buffer that moves 9-bit words from a write clock domain to an unrelated read clock domain. The depth is a power-of-two parameter between 256 and 4096 words. Each domain keeps its own binary and Gray-coded pointer and sees the other side's pointer through a two-flop synchronizer.

Four active-low status flags report the fill level. Full and almost-full are registered in the write clock domain, which is the side they throttle. Empty and almost-empty are registered in the read clock domain. Two offset registers set the almost-full and almost-empty thresholds. A single-cycle load strobe in the write domain sets them, and the read domain works from a synchronized copy of the empty offset.

A producer writes while full is high. A consumer reads while empty is high and takes the word from the data output after its read edge. Because pointer crossings add latency, the flags release late. They never claim space or data that does not exist.

Top module: `xclk_fifo`

## Requirements
- R1: rstN is active low and asynchronous. While it is low and after its release, the FIFO holds no words, emptyN and almostEmptyN are 0, fullN and almostFullN are 1, rdData is 0, and both offsets are 7.
- R2: Words leave in the order they were accepted. On a rising rdClk edge with rdEn=1 and emptyN=1, rdData loads the oldest stored word. On any other rdClk edge, rdData holds its value.
- R3: A write offered while fullN is 0 is dropped and never appears at rdData. A read requested while emptyN is 0 changes neither rdData nor the stored words.
- R4: On each rising wrClk edge, fullN is set to 0 when the write-side word count after that edge equals DEPTH, and to 1 otherwise. With no reads since reset, fullN goes low at the edge of the DEPTH-th accepted write.
- R5: On each rising rdClk edge, emptyN is set to 0 when the read-side word count after that edge is 0 (read pointer equals write pointer), and to 1 otherwise.
- R6: almostFullN is 0 when the write-side count is DEPTH-m or more, and 1 when it is DEPTH-m-1 or less. Here m is the full offset. The flag is updated on wrClk.
- R7: almostEmptyN is 0 when the read-side count is n or less, and 1 when it is n+1 or more. Here n is the empty offset. The flag is updated on rdClk.
- R8: On a rising wrClk edge with cfgLoad=1, cfgValue (AW bits) is loaded into the full offset when cfgSel=1, or into the empty offset when cfgSel=0. Values below 1 become 1, and values above DEPTH-2 become DEPTH-2.
- R9: Each side's flags may stay asserted (low) for a few of its own clocks after the other side has freed space or added data, but are never deasserted while the true condition holds. Once both sides have been idle for ten read clocks, all four flags match the true count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write domain clock |
| rstN | input | 1 | Asynchronous active-low reset for both domains |
| wrEn | input | 1 | Write request |
| wrData | input | DATA_W | Word to store |
| cfgLoad | input | 1 | Offset load strobe (write domain) |
| cfgSel | input | 1 | 1 selects the full offset, 0 the empty offset |
| cfgValue | input | AW | Offset value, clamped to 1..DEPTH-2 |
| fullN | output | 1 | Low when DEPTH words are stored |
| almostFullN | output | 1 | Low when count is at least DEPTH-m |
| rdClk | input | 1 | Read domain clock |
| rdEn | input | 1 | Read request |
| rdData | output | DATA_W | Last word read |
| emptyN | output | 1 | Low when no word is stored |
| almostEmptyN | output | 1 | Low when count is at most n |

## Verification
A write and a read can land in the same moment at either end of the range. A write can take the last free slot while the read side is freeing one, and a read can take the last word while a new one is being written. Two traffic phases provoke this with rate-controlled requests on clocks of 4 ns and 7 ns, one phase biased toward filling and one toward draining. They are judged by checking every word against a behavioural queue, and by requiring on every clock that no flag is released while the queue count says its condition still holds.

// File: rtl/xclk_fifo_pkg.sv
package xclk_fifo_pkg;

  // strobes from the control into the storage
  typedef struct packed {
    logic push;   // write-domain: store wrData at wrAddr
    logic pop;    // read-domain: load rdData from rdAddr
  } fifoStrobe_t;

  localparam int OFFSET_DEFAULT = 7;
  localparam logic SEL_FULL_OFFSET = 1'b1;
  localparam int GRAY_MAX_W = 16;

  function automatic logic [GRAY_MAX_W-1:0] grayToBin(input logic [GRAY_MAX_W-1:0] g);
    logic [GRAY_MAX_W-1:0] b;
    b[GRAY_MAX_W-1] = g[GRAY_MAX_W-1];
    for (int i = GRAY_MAX_W - 2; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction

endpackage

// File: rtl/xclk_fifo_sync.sv
module xclk_fifo_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      meta <= INIT;
      q    <= INIT;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end

endmodule

// File: rtl/xclk_fifo_ctrl.sv
module xclk_fifo_ctrl
  import xclk_fifo_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic        wrClk,
  input  logic        rdClk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic        rdEn,
  input  logic        cfgLoad,
  input  logic        cfgSel,
  input  logic [AW-1:0] cfgValue,
  output fifoStrobe_t strobe,
  output logic [AW-1:0] wrAddr,
  output logic [AW-1:0] rdAddr,
  output logic        fullN,
  output logic        almostFullN,
  output logic        emptyN,
  output logic        almostEmptyN
);

  localparam logic [PW-1:0] FULL_LEVEL = PW'(DEPTH);
  localparam logic [AW-1:0] OFF_MIN = AW'(1);
  localparam logic [AW-1:0] OFF_MAX = AW'(DEPTH - 2);
  localparam logic [AW-1:0] OFF_DEF = AW'(OFFSET_DEFAULT);

  // write domain
  logic [PW-1:0] wrPtrBin, wrPtrGray, wrPtrNext, rdPtrSeen, wrLevelNext, afLimit;
  logic [PW-1:0] rdGraySync;
  logic [AW-1:0] fullOff, emptyOffW, cfgClamped;
  logic          push;

  // read domain
  logic [PW-1:0] rdPtrBin, rdPtrGray, rdPtrNext, wrPtrSeen, rdLevelNext;
  logic [PW-1:0] wrGraySync;
  logic [AW-1:0] emptyOffR;
  logic          pop;

  assign push = wrEn & fullN;
  assign pop  = rdEn & emptyN;

  always_comb begin
    strobe.push = push;
    strobe.pop  = pop;
  end

  assign wrAddr = wrPtrBin[AW-1:0];
  assign rdAddr = rdPtrBin[AW-1:0];

  // ---------------- write side ----------------
  always_comb begin
    wrPtrNext   = wrPtrBin + PW'(push);
    rdPtrSeen   = PW'(grayToBin(GRAY_MAX_W'(rdGraySync)));
    wrLevelNext = wrPtrNext - rdPtrSeen;
    afLimit     = FULL_LEVEL - PW'(fullOff);
    if (cfgValue < OFF_MIN)      cfgClamped = OFF_MIN;
    else if (cfgValue > OFF_MAX) cfgClamped = OFF_MAX;
    else                         cfgClamped = cfgValue;
  end

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      wrPtrBin    <= '0;
      wrPtrGray   <= '0;
      fullN       <= 1'b1;
      almostFullN <= 1'b1;
      fullOff     <= OFF_DEF;
      emptyOffW   <= OFF_DEF;
    end else begin
      wrPtrBin    <= wrPtrNext;
      wrPtrGray   <= wrPtrNext ^ (wrPtrNext >> 1);
      fullN       <= (wrLevelNext != FULL_LEVEL);
      almostFullN <= (wrLevelNext < afLimit);
      if (cfgLoad) begin
        if (cfgSel == SEL_FULL_OFFSET) fullOff <= cfgClamped;
        else                           emptyOffW <= cfgClamped;
      end
    end
  end

  // ---------------- read side ----------------
  always_comb begin
    rdPtrNext   = rdPtrBin + PW'(pop);
    wrPtrSeen   = PW'(grayToBin(GRAY_MAX_W'(wrGraySync)));
    rdLevelNext = wrPtrSeen - rdPtrNext;
  end

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      rdPtrBin     <= '0;
      rdPtrGray    <= '0;
      emptyN       <= 1'b0;
      almostEmptyN <= 1'b0;
    end else begin
      rdPtrBin     <= rdPtrNext;
      rdPtrGray    <= rdPtrNext ^ (rdPtrNext >> 1);
      emptyN       <= (rdLevelNext != '0);
      almostEmptyN <= (rdLevelNext > PW'(emptyOffR));
    end
  end

  // ---------------- crossings ----------------
  xclk_fifo_sync #(.W(PW), .INIT('0)) u_rdToWr (
    .clk(wrClk), .rstN(rstN), .d(rdPtrGray), .q(rdGraySync)
  );

  xclk_fifo_sync #(.W(PW), .INIT('0)) u_wrToRd (
    .clk(rdClk), .rstN(rstN), .d(wrPtrGray), .q(wrGraySync)
  );

  // empty offset is quasi-static: changed only while the read side is idle
  xclk_fifo_sync #(.W(AW), .INIT(OFF_DEF)) u_offToRd (
    .clk(rdClk), .rstN(rstN), .d(emptyOffW), .q(emptyOffR)
  );

endmodule

// File: rtl/xclk_fifo_datapath.sv
module xclk_fifo_datapath
  import xclk_fifo_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int DATA_W = 9,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  fifoStrobe_t       strobe,
  input  logic [AW-1:0]     wrAddr,
  input  logic [AW-1:0]     rdAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge wrClk) begin
    if (strobe.push) mem[wrAddr] <= wrData;
  end

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN)           rdData <= '0;
    else if (strobe.pop) rdData <= mem[rdAddr];
  end

endmodule

// File: rtl/xclk_fifo.sv
module xclk_fifo
  import xclk_fifo_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int DATA_W = 9,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              wrClk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              cfgLoad,
  input  logic              cfgSel,
  input  logic [AW-1:0]     cfgValue,
  output logic              fullN,
  output logic              almostFullN,
  input  logic              rdClk,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  output logic              emptyN,
  output logic              almostEmptyN
);

  fifoStrobe_t   strobe;
  logic [AW-1:0] wrAddr;
  logic [AW-1:0] rdAddr;

  xclk_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN),
    .wrEn(wrEn), .rdEn(rdEn),
    .cfgLoad(cfgLoad), .cfgSel(cfgSel), .cfgValue(cfgValue),
    .strobe(strobe), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .fullN(fullN), .almostFullN(almostFullN),
    .emptyN(emptyN), .almostEmptyN(almostEmptyN)
  );

  xclk_fifo_datapath #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_datapath (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN),
    .strobe(strobe), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .wrData(wrData), .rdData(rdData)
  );

endmodule

// File: rtl/xclk_fifo_checker.sv
module xclk_fifo_checker #(
  parameter int AW = 8,
  parameter int DATA_W = 9
) (
  input logic              wrClk,
  input logic              rdClk,
  input logic              rstN,
  input logic              wrEn,
  input logic              rdEn,
  input logic              fullN,
  input logic              almostFullN,
  input logic              emptyN,
  input logic              almostEmptyN,
  input logic [DATA_W-1:0] rdData,
  input logic [AW-1:0]     wrAddr,
  input logic [AW-1:0]     rdAddr
);

  // R3: a blocked write leaves the write pointer where it was
  assert_no_overflow_R3: assert property (@(posedge wrClk) disable iff (!rstN)
    !fullN |=> $stable(wrAddr))
    else $error("write pointer moved while full");

  // R3: a blocked read leaves the read pointer where it was
  assert_no_underflow_R3: assert property (@(posedge rdClk) disable iff (!rstN)
    !emptyN |=> $stable(rdAddr))
    else $error("read pointer moved while empty");

  assert_rd_hold_R2: assert property (@(posedge rdClk) disable iff (!rstN)
    !(rdEn && emptyN) |=> $stable(rdData))
    else $error("rdData changed without a read");

  assert_full_needs_write_R4: assert property (@(posedge wrClk) disable iff (!rstN)
    $fell(fullN) |-> $past(wrEn))
    else $error("full asserted without a write");

  assert_empty_needs_read_R5: assert property (@(posedge rdClk) disable iff (!rstN)
    $fell(emptyN) |-> $past(rdEn))
    else $error("empty asserted without a read");

  assert_full_in_almost_full_R6: assert property (@(posedge wrClk) disable iff (!rstN)
    !fullN |-> !almostFullN)
    else $error("full without almost-full");

  assert_empty_in_almost_empty_R7: assert property (@(posedge rdClk) disable iff (!rstN)
    !emptyN |-> !almostEmptyN)
    else $error("empty without almost-empty");

endmodule

bind xclk_fifo xclk_fifo_checker #(.AW(AW), .DATA_W(DATA_W)) u_checker (
  .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN),
  .wrEn(wrEn), .rdEn(rdEn),
  .fullN(fullN), .almostFullN(almostFullN),
  .emptyN(emptyN), .almostEmptyN(almostEmptyN),
  .rdData(rdData), .wrAddr(wrAddr), .rdAddr(rdAddr)
);

// File: tb/xclk_fifo_bench.sv
`timescale 1ns/100ps
module xclk_fifo_bench;

  localparam int D = 256;
  localparam int AW = 8;

  logic wrClk = 1'b0, rdClk = 1'b0, rstN;
  logic wrEn = 1'b0, rdEn = 1'b0, cfgLoad = 1'b0, cfgSel = 1'b0;
  logic [8:0] wrData = '0;
  logic [AW-1:0] cfgValue = '0;
  logic fullN, almostFullN, emptyN, almostEmptyN;
  logic [8:0] rdData;

  always #2   wrClk = ~wrClk;   // 250 MHz
  always #3.5 rdClk = ~rdClk;

  xclk_fifo #(.DEPTH(D), .DATA_W(9)) u_xclk_fifo (
    .wrClk(wrClk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .cfgLoad(cfgLoad), .cfgSel(cfgSel), .cfgValue(cfgValue),
    .fullN(fullN), .almostFullN(almostFullN),
    .rdClk(rdClk), .rdEn(rdEn), .rdData(rdData),
    .emptyN(emptyN), .almostEmptyN(almostEmptyN)
  );

  // behavioural reference
  logic [8:0] q[$];
  int  mOff = 7, nOff = 7;
  int  errors = 0, checks = 0;
  bit  run = 0, done = 0, exactW = 0, exactR = 0;
  int  wrLeft = 0;
  bit  wrRand = 0, rdRand = 0, rdAll = 0;
  int  wrRate = 0, rdRate = 0;
  logic [8:0] nextWord = 9'd1, expWord = '0, lastWord = '0;
  bit  popPending = 0;
  string afTag = "R6", aeTag = "R7", dataTag = "R2";

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic checkW();
    int cnt = q.size();
    if (exactW) begin
      chk(fullN == (cnt != D), "R4", fullN, cnt != D);
      chk(almostFullN == (cnt < D - mOff), afTag, almostFullN, cnt < D - mOff);
    end else begin
      if (cnt == D) chk(!fullN, "R9 full", fullN, 0);
      if (cnt >= D - mOff) chk(!almostFullN, "R9 almost-full", almostFullN, 0);
    end
  endtask

  task automatic checkR();
    int cnt = q.size();
    if (exactR) begin
      chk(emptyN == (cnt != 0), "R5", emptyN, cnt != 0);
      chk(almostEmptyN == (cnt > nOff), aeTag, almostEmptyN, cnt > nOff);
    end else begin
      if (cnt == 0) chk(!emptyN, "R9 empty", emptyN, 0);
      if (cnt <= nOff) chk(!almostEmptyN, "R9 almost-empty", almostEmptyN, 0);
    end
  endtask

  // write-side driver and checker
  initial begin : wrProc
    wait (run);
    forever begin
      bit want;
      @(negedge wrClk);
      checkW();
      want = (wrLeft > 0) || (wrRand && ($urandom_range(0, 99) < wrRate));
      if (wrLeft > 0) wrLeft--;
      wrEn = want;
      wrData = nextWord;
      if (want) begin
        if (fullN) q.push_back(nextWord);
        nextWord = nextWord + 9'd1;
      end
    end
  end

  // read-side driver and checker
  initial begin : rdProc
    wait (run);
    forever begin
      bit want;
      @(negedge rdClk);
      checkR();
      if (popPending) begin
        chk(rdData == expWord, dataTag, rdData, expWord);
        lastWord = expWord;
      end else begin
        chk(rdData == lastWord, "R2 R3 hold", rdData, lastWord);
      end
      want = rdAll || (rdRand && ($urandom_range(0, 99) < rdRate));
      rdEn = want;
      if (want && emptyN) begin
        expWord = q.pop_front();
        popPending = 1;
      end else begin
        popPending = 0;
      end
    end
  end

  task automatic settle();
    exactW = 0;
    exactR = 0;
    repeat (10) @(negedge rdClk);
  endtask

  task automatic idleExact();
    exactW = 1;
    exactR = 1;
    repeat (6) @(negedge rdClk);
    exactW = 0;
    exactR = 0;
  endtask

  task automatic fillExact(input int n);
    exactR = 0;
    exactW = 1;
    wrLeft = n;
    while (wrLeft > 0) @(negedge wrClk);
    repeat (2) @(negedge wrClk);
    settle();
  endtask

  task automatic drainExact();
    exactW = 0;
    exactR = 1;
    rdAll = 1;
    while (q.size() != 0) @(negedge rdClk);
    repeat (4) @(negedge rdClk);
    rdAll = 0;
    settle();
  endtask

  task automatic loadCfg(input bit sel, input int val);
    int c;
    @(negedge wrClk);
    cfgLoad = 1'b1;
    cfgSel = sel;
    cfgValue = AW'(val);
    c = (val < 1) ? 1 : ((val > D - 2) ? D - 2 : val);
    if (sel) mOff = c; else nOff = c;
    @(negedge wrClk);
    cfgLoad = 1'b0;
  endtask

  initial begin : mainSeq
    rstN = 1'b1;
    #1 rstN = 1'b0;
    #29;
    chk(fullN == 1'b1, "R1 fullN", fullN, 1);
    chk(almostFullN == 1'b1, "R1 almostFullN", almostFullN, 1);
    chk(emptyN == 1'b0, "R1 emptyN", emptyN, 0);
    chk(almostEmptyN == 1'b0, "R1 almostEmptyN", almostEmptyN, 0);
    chk(rdData == 9'd0, "R1 rdData", rdData, 0);
    #10 rstN = 1'b1;
    run = 1;

    // default offsets, overfill by four, then full drain
    afTag = "R1 R6"; aeTag = "R1 R7"; dataTag = "R2 R3";
    idleExact();
    fillExact(D + 4);
    idleExact();
    drainExact();
    idleExact();

    // loaded offsets
    afTag = "R6 R8"; aeTag = "R7 R8"; dataTag = "R2";
    loadCfg(1'b1, 20);
    loadCfg(1'b0, 3);
    settle();
    idleExact();
    fillExact(D - 20 + 2);
    idleExact();
    drainExact();

    // clamping at both ends
    loadCfg(1'b1, 0);
    loadCfg(1'b0, 255);
    settle();
    fillExact(D);
    idleExact();
    drainExact();
    loadCfg(1'b1, 255);
    loadCfg(1'b0, 0);
    settle();
    fillExact(4);
    idleExact();
    drainExact();

    // concurrent traffic toward full, then toward empty
    afTag = "R6"; aeTag = "R7"; dataTag = "R2 concurrent";
    loadCfg(1'b1, 7);
    loadCfg(1'b0, 7);
    settle();
    wrRate = 70; rdRate = 45; wrRand = 1; rdRand = 1;
    repeat (1500) @(negedge wrClk);
    wrRate = 30; rdRate = 80;
    repeat (1500) @(negedge wrClk);
    wrRand = 0; rdRand = 0;
    settle();
    idleExact();
    drainExact();
    idleExact();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : watchdog
    #600000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule